// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that fetches, decodes and retires one instruction on every rising clock edge. It runs ten instructions: word load, word store, six register-to-register ALU operations, branch-if-equal and an absolute jump. It keeps a program counter, a 32-entry register file and two separate word memories, one for instructions and one for data. A fixed opcode decoder drives the datapath. Two dedicated adders form the sequential address and the branch target, so no hardware is shared within a cycle.

Two faults are trapped: an unknown opcode or function code, and signed overflow from a register add or subtract. A trapped instruction writes neither the register file nor memory. It saves its own address and a one-bit cause, then sends the core to a fixed handler address.

Both memories are filled through a load port. The port uses a valid/ready handshake whose ready is the reset input itself. A word is taken on each rising edge where valid and ready are both high. While the core runs, ready stays low, so back-pressure holds indefinitely and offered words are dropped without effect. Retirement is visible on plain status pins: the current PC and instruction, the register write, the memory store, and the trap state.

Top module: `scycle_core`

## Requirements
- R1: `rst` is synchronous and active high. An edge with `rst` high sets `pc_o` to 0 and clears `epc_o` and `cause_o`. While `rst` is high, `wb_en`, `st_en` and `exc_o` are 0.
- R2: An R-type word has bits 31:26 = 0, rs in 25:21, rt in 20:16, rd in 15:11, zero in 10:6 and the function code in 5:0. The function codes are 32 add, 34 subtract, 36 AND, 37 OR, 39 NOR and 42 signed set-less-than (result 1 or 0). The result is written to rd.
- R3: Opcode 35 loads the data word at rs + sign-extended bits 15:0 into rt. Opcode 43 stores rt at that address. Data word index = address bits [7:2].
- R4: For opcode 4, when rs equals rt the next PC is PC+4 plus the sign-extended offset shifted left by two. Otherwise the next PC is PC+4.
- R5: For opcode 2, the next PC is the top 4 bits of PC+4, then bits 25:0, then two zeros. Nothing is written.
- R6: Register 0 reads as zero. A write aimed at it never raises `wb_en`.
- R7: An unknown opcode, an unknown function code, or a nonzero bits 10:6 in an R-type word raises `exc_o`. The instruction's writes are suppressed. The next edge loads 0x80000180 into the PC, the faulting PC into `epc_o`, and 0 into `cause_o`.
- R8: Signed overflow on an R-type add or subtract is handled as in R7, except that `cause_o` becomes 1. Overflow in a load or store address add is not trapped.
- R9: A source register reads the value held at the start of the cycle, so `add r1,r1,r1` doubles r1. The next instruction sees the updated value.
- R10: Loads, stores and legal ALU operations advance the PC by 4. The instruction index is PC bits [8:2].
- R11: `ld_ready` equals `rst`. A word with `ld_sel`=0 goes to instruction index `ld_addr`, and with `ld_sel`=1 to data index `ld_addr[5:0]`. Words offered while running change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word accepted (high only in reset) |
| ld_sel | input | 1 | 0 = instruction memory, 1 = data memory |
| ld_addr | input | 7 | Word index for the load |
| ld_data | input | 32 | Word to load |
| pc_o | output | 32 | Address of the instruction in flight |
| instr_o | output | 32 | Instruction in flight |
| wb_en | output | 1 | Register write at the next edge |
| wb_addr | output | 5 | Register written |
| wb_data | output | 32 | Value written |
| st_en | output | 1 | Data store at the next edge |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Stored word |
| exc_o | output | 1 | Instruction in flight traps |
| epc_o | output | 32 | Saved address of the last trapping instruction |
| cause_o | output | 1 | Last trap cause: 0 illegal, 1 overflow |

## Verification
The properties assume the instruction on `instr_o` was fetched from a word that was loaded during reset. They also assume that reset lasts at least one edge before the core runs, so the PC and trap registers start from known values. The stimulus reloads programs only while reset is held. Each program reads only registers and data words that it, or an earlier program, has written. Every handler word that can be reached is loaded, so no instruction is fetched from an uninitialised location.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int WORD_W  = 32;
  localparam int REG_AW  = 5;
  localparam int NREGS   = 1 << REG_AW;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluop_e;

  typedef enum logic [2:0] {
    ALU_AND,
    ALU_OR,
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_NOR
  } alufn_e;

  typedef struct packed {
    logic   dst_rd;
    logic   src_imm;
    logic   wb_mem;
    logic   reg_we;
    logic   mem_rd;
    logic   mem_we;
    logic   branch;
    logic   jump;
    aluop_e aluop;
    logic   bad_op;
  } ctrl_t;

endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl       = '0;
    ctrl.aluop = AOP_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.aluop  = AOP_FUNCT;
      end
      OP_LW: begin
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluop  = AOP_SUB;
      end
      OP_JMP: begin
        ctrl.jump = 1'b1;
      end
      default: begin
        ctrl.bad_op = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
(
  input  aluop_e            aluop,
  input  logic [5:0]        funct,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] y,
  output logic              zero,
  output logic              ovf,
  output logic              bad_fn
);

  alufn_e            fn;
  logic              arith;
  logic              inv;
  logic [WORD_W-1:0] bx;
  logic [WORD_W-1:0] sum;
  logic              ovf_raw;
  logic              less;

  // Operation select from the decoder's class and the function field
  always_comb begin
    fn     = ALU_ADD;
    arith  = 1'b0;
    bad_fn = 1'b0;
    case (aluop)
      AOP_ADD: fn = ALU_ADD;
      AOP_SUB: fn = ALU_SUB;
      default: begin
        case (funct)
          FN_ADD: begin fn = ALU_ADD; arith = 1'b1; end
          FN_SUB: begin fn = ALU_SUB; arith = 1'b1; end
          FN_AND: fn = ALU_AND;
          FN_OR:  fn = ALU_OR;
          FN_NOR: fn = ALU_NOR;
          FN_SLT: fn = ALU_SLT;
          default: bad_fn = 1'b1;
        endcase
      end
    endcase
  end

  assign inv     = (fn == ALU_SUB) || (fn == ALU_SLT);
  assign bx      = inv ? ~b : b;
  assign sum     = a + bx + {{(WORD_W-1){1'b0}}, inv};
  assign ovf_raw = (a[WORD_W-1] == bx[WORD_W-1]) && (sum[WORD_W-1] != a[WORD_W-1]);
  assign less    = sum[WORD_W-1] ^ ovf_raw;

  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {{(WORD_W-1){1'b0}}, less};
      default: y = sum;
    endcase
  end

  assign zero = (y == '0);
  assign ovf  = arith & ovf_raw;

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int  W     = 32,
  parameter int  DEPTH = 32,
  parameter int  NRD   = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*W-1:0]  rdata
);

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [AW-1:0] ra;
    assign ra = raddr[p*AW +: AW];
    assign rdata[p*W +: W] = (ra == '0) ? '0 : regs[ra];
  end

endmodule

// File: rtl/scycle_core.sv
module scycle_core
  import core_pkg::*;
#(
  parameter int          IMEM_WORDS = 128,
  parameter int          DMEM_WORDS = 64,
  parameter logic [31:0] TRAP_VEC   = 32'h8000_0180,
  localparam int         IAW = $clog2(IMEM_WORDS),
  localparam int         DAW = $clog2(DMEM_WORDS),
  localparam int         LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_sel,
  input  logic [LAW-1:0]    ld_addr,
  input  logic [31:0]       ld_data,
  output logic [31:0]       pc_o,
  output logic [31:0]       instr_o,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_addr,
  output logic [31:0]       wb_data,
  output logic              st_en,
  output logic [31:0]       st_addr,
  output logic [31:0]       st_data,
  output logic              exc_o,
  output logic [31:0]       epc_o,
  output logic              cause_o
);

  logic [WORD_W-1:0] pc_q, epc_q;
  logic              cause_q;
  logic [WORD_W-1:0] imem [IMEM_WORDS];
  logic [WORD_W-1:0] dmem [DMEM_WORDS];

  logic              ld_fire;
  logic [WORD_W-1:0] instr;
  logic [5:0]        opcode, funct;
  logic [4:0]        shamt;
  logic [REG_AW-1:0] rs, rt, rd, dest;
  logic [15:0]       imm;
  logic [WORD_W-1:0] sext;
  ctrl_t             ctrl;
  logic [WORD_W-1:0] rs_val, rt_val, opb, alu_y, mem_q;
  logic              alu_zero, alu_ovf, bad_fn;
  logic              illegal, trap;
  logic [WORD_W-1:0] pc_seq, pc_br, pc_jmp, pc_next;

  // Load port: accepted only while the core is held in reset
  assign ld_ready = rst;
  assign ld_fire  = ld_valid & rst;

  always_ff @(posedge clk) begin
    if (ld_fire && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  // Fetch and field split
  assign instr  = imem[pc_q[IAW+1:2]];
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];
  assign sext   = {{(WORD_W-16){imm[15]}}, imm};

  core_decode u_dec (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  core_regfile #(
    .W     (WORD_W),
    .DEPTH (NREGS),
    .NRD   (2)
  ) u_rf (
    .clk   (clk),
    .we    (wb_en),
    .waddr (dest),
    .wdata (wb_data),
    .raddr ({rt, rs}),
    .rdata ({rt_val, rs_val})
  );

  assign opb = ctrl.src_imm ? sext : rt_val;

  core_alu u_alu (
    .aluop  (ctrl.aluop),
    .funct  (funct),
    .a      (rs_val),
    .b      (opb),
    .y      (alu_y),
    .zero   (alu_zero),
    .ovf    (alu_ovf),
    .bad_fn (bad_fn)
  );

  assign mem_q = ctrl.mem_rd ? dmem[alu_y[DAW+1:2]] : '0;

  // Trap detection
  assign illegal = ctrl.bad_op |
                   ((ctrl.aluop == AOP_FUNCT) & (bad_fn | (shamt != 5'd0)));
  assign trap    = ~rst & (illegal | alu_ovf);

  // Write-back and store
  assign dest    = ctrl.dst_rd ? rd : rt;
  assign wb_data = ctrl.wb_mem ? mem_q : alu_y;
  assign wb_en   = ~rst & ctrl.reg_we & ~trap & (dest != '0);
  assign wb_addr = dest;
  assign st_en   = ~rst & ctrl.mem_we & ~trap;
  assign st_addr = alu_y;
  assign st_data = rt_val;

  always_ff @(posedge clk) begin
    if (ld_fire && ld_sel)  dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (st_en)         dmem[alu_y[DAW+1:2]]  <= rt_val;
  end

  // Next PC: two dedicated adders plus the jump splice
  assign pc_seq = pc_q + 32'd4;
  assign pc_br  = pc_seq + {sext[WORD_W-3:0], 2'b00};
  assign pc_jmp = {pc_seq[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (trap)                          pc_next = TRAP_VEC;
    else if (ctrl.jump)                pc_next = pc_jmp;
    else if (ctrl.branch && alu_zero)  pc_next = pc_br;
    else                               pc_next = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      epc_q   <= '0;
      cause_q <= 1'b0;
    end else begin
      pc_q <= pc_next;
      if (trap) begin
        epc_q   <= pc_q;
        cause_q <= ~illegal;
      end
    end
  end

  assign pc_o    = pc_q;
  assign instr_o = instr;
  assign exc_o   = trap;
  assign epc_o   = epc_q;
  assign cause_o = cause_q;

endmodule

// File: rtl/scycle_core_chk.sv
module scycle_core_chk
  import core_pkg::*;
#(
  parameter logic [31:0] TRAP_VEC = 32'h8000_0180
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o,
  input logic        exc_o,
  input logic [31:0] epc_o,
  input logic        cause_o,
  input logic        wb_en,
  input logic [4:0]  wb_addr
);

  logic [5:0] op, fn;
  assign op = instr_o[31:26];
  assign fn = instr_o[5:0];

  function automatic logic [31:0] jdest(input logic [31:0] p, input logic [31:0] i);
    logic [31:0] n;
    n = p + 32'd4;
    return {n[31:28], i[25:0], 2'b00};
  endfunction

  function automatic logic [31:0] bdest(input logic [31:0] p, input logic [31:0] i);
    return p + 32'd4 + {{14{i[15]}}, i[15:0], 2'b00};
  endfunction

  // R10
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!exc_o && (op == OP_LW || op == OP_SW)) |=> pc_o == $past(pc_o) + 32'd4);

  // R5
  jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!exc_o && op == OP_JMP) |=> pc_o == jdest($past(pc_o), $past(instr_o)));

  // R4
  beq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!exc_o && op == OP_BEQ) |=>
      (pc_o == $past(pc_o) + 32'd4 || pc_o == bdest($past(pc_o), $past(instr_o))));

  // R7
  trap_vec_chk: assert property (@(posedge clk) disable iff (rst)
    exc_o |=> (pc_o == TRAP_VEC && epc_o == $past(pc_o)));

  // R7
  epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exc_o |=> $stable(epc_o));

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_o && op == OP_RTYPE && instr_o[10:6] == 5'd0 && (fn == FN_ADD || fn == FN_SUB))
      |=> cause_o);

  // R7
  ill_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_o && op != OP_RTYPE) |=> !cause_o);

  // R6
  r0_write_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> wb_addr != 5'd0);

endmodule

bind scycle_core scycle_core_chk #(.TRAP_VEC(TRAP_VEC)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .pc_o    (pc_o),
  .instr_o (instr_o),
  .exc_o   (exc_o),
  .epc_o   (epc_o),
  .cause_o (cause_o),
  .wb_en   (wb_en),
  .wb_addr (wb_addr)
);

// File: tb/scycle_core_tb_top.sv
module scycle_core_tb_top;

  localparam int IW = 128;
  localparam int DW = 64;
  localparam logic [31:0] HANDLER = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_sel = 1'b0;
  logic [6:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, instr_o, wb_data, st_addr, st_data, epc_o;
  logic [4:0]  wb_addr;
  logic        wb_en, st_en, exc_o, cause_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scycle_core dut_i (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_o(pc_o), .instr_o(instr_o),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data),
    .exc_o(exc_o), .epc_o(epc_o), .cause_o(cause_o)
  );

  // Behavioural reference state
  logic [31:0] m_imem [IW];
  logic [31:0] m_dmem [DW];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc, m_epc;
  logic        m_cause;
  string       prev_tag = "R1";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn, int sh = 0);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] enc_j(int tgt);
    return {6'd2, tgt[25:0]};
  endfunction

  task automatic put(input bit sel, input int idx, input logic [31:0] d);
    ld_valid = 1'b1;
    ld_sel   = sel;
    ld_addr  = idx[6:0];
    ld_data  = d;
    if (sel) m_dmem[idx % DW] = d;
    else     m_imem[idx % IW] = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic enter_reset();
    rst = 1'b1;
    @(negedge clk);
    m_pc = '0; m_epc = '0; m_cause = 1'b0;
    prev_tag = "R1";
  endtask

  task automatic check_reset();
    #1;
    chk(pc_o === 32'd0,    "R1", "reset pc",    pc_o, 32'd0);
    chk(epc_o === 32'd0,   "R1", "reset epc",   epc_o, 32'd0);
    chk(cause_o === 1'b0,  "R1", "reset cause", {31'd0, cause_o}, 32'd0);
    chk(!wb_en && !st_en && !exc_o, "R1", "no writes in reset",
        {29'd0, wb_en, st_en, exc_o}, 32'd0);
    chk(ld_ready === 1'b1, "R11", "ready in reset", {31'd0, ld_ready}, 32'd1);
  endtask

  // One cycle of the reference: compare outputs, then advance the model
  task automatic step();
    logic [31:0] ins, a, b, sx, npc, r, addr;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    logic        bad, ovf, e_wb, e_st;
    logic [4:0]  e_wa;
    logic [31:0] e_wd;
    longint      s;
    string       tag;
    ins = m_imem[m_pc[8:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    a  = (rs == 0) ? 32'd0 : m_reg[rs];
    b  = (rt == 0) ? 32'd0 : m_reg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    npc = m_pc + 32'd4;
    bad = 1'b0; ovf = 1'b0; e_wb = 1'b0; e_st = 1'b0; e_wa = '0; e_wd = '0; addr = '0;
    r = '0; tag = "R10";
    case (op)
      6'd0: begin
        tag = "R2";
        if (ins[10:6] != 0) bad = 1'b1;
        else begin
          case (fn)
            6'd32: begin s = longint'($signed(a)) + longint'($signed(b)); r = a + b;
                         ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            6'd34: begin s = longint'($signed(a)) - longint'($signed(b)); r = a - b;
                         ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            6'd36: r = a & b;
            6'd37: r = a | b;
            6'd39: r = ~(a | b);
            6'd42: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: bad = 1'b1;
          endcase
        end
        if (rd == rs || rd == rt) tag = "R9";
        if (rd == 0) tag = "R6";
        e_wa = rd; e_wd = r; e_wb = (rd != 0);
      end
      6'd35: begin
        tag = "R3"; addr = a + sx;
        e_wa = rt; e_wd = m_dmem[addr[7:2]]; e_wb = (rt != 0);
      end
      6'd43: begin
        tag = "R3"; addr = a + sx; e_st = 1'b1;
      end
      6'd4: begin
        tag = "R4";
        if (a == b) npc = m_pc + 32'd4 + {sx[29:0], 2'b00};
      end
      6'd2: begin
        tag = "R5";
        npc = {npc[31:28], ins[25:0], 2'b00};
      end
      default: bad = 1'b1;
    endcase
    if (bad || ovf) begin
      tag = bad ? "R7" : "R8";
      e_wb = 1'b0; e_st = 1'b0; npc = HANDLER;
    end

    chk(pc_o === m_pc, prev_tag, "pc", pc_o, m_pc);
    chk(instr_o === ins, "R11", "fetched word", instr_o, ins);
    chk(ld_ready === 1'b0, "R11", "ready while running", {31'd0, ld_ready}, 32'd0);
    chk(exc_o === (bad | ovf), tag, "trap flag", {31'd0, exc_o}, {31'd0, bad | ovf});
    chk(wb_en === e_wb, tag, "reg write enable", {31'd0, wb_en}, {31'd0, e_wb});
    if (e_wb) begin
      chk(wb_addr === e_wa, tag, "reg write addr", {27'd0, wb_addr}, {27'd0, e_wa});
      chk(wb_data === e_wd, tag, "reg write data", wb_data, e_wd);
    end
    chk(st_en === e_st, tag, "store enable", {31'd0, st_en}, {31'd0, e_st});
    if (e_st) begin
      chk(st_addr === addr, "R3", "store addr", st_addr, addr);
      chk(st_data === b,    "R3", "store data", st_data, b);
    end
    chk(epc_o === m_epc, m_cause ? "R8" : "R7", "epc", epc_o, m_epc);
    chk(cause_o === m_cause, m_cause ? "R8" : "R7", "cause",
        {31'd0, cause_o}, {31'd0, m_cause});

    if (e_wb) m_reg[e_wa] = e_wd;
    if (e_st) m_dmem[addr[7:2]] = b;
    if (bad || ovf) begin m_epc = m_pc; m_cause = ovf & ~bad; end
    m_pc = npc;
    prev_tag = tag;
  endtask

  task automatic run(input int n);
    rst = 1'b0;
    for (int i = 0; i < n; i++) begin
      #1;
      step();
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    @(negedge clk);
    enter_reset();

    // Phase A: ALU, memory, branch, jump, add overflow
    put(1, 0, 32'd5);
    put(1, 1, 32'd7);
    put(1, 2, 32'h7FFF_FFFF);
    put(1, 3, 32'h8000_0000);
    put(1, 4, 32'hFFFF_FFFD);
    put(0, 0,  enc_i(35, 0, 1, 0));
    put(0, 1,  enc_i(35, 0, 2, 4));
    put(0, 2,  enc_r(1, 2, 3, 32));
    put(0, 3,  enc_r(1, 2, 4, 34));
    put(0, 4,  enc_r(1, 2, 5, 36));
    put(0, 5,  enc_r(1, 2, 6, 37));
    put(0, 6,  enc_r(4, 1, 7, 42));
    put(0, 7,  enc_r(1, 4, 8, 42));
    put(0, 8,  enc_r(1, 2, 9, 39));
    put(0, 9,  enc_r(1, 2, 0, 32));
    put(0, 10, enc_r(0, 1, 10, 32));
    put(0, 11, enc_r(1, 1, 1, 32));
    put(0, 12, enc_i(43, 0, 1, 20));
    put(0, 13, enc_i(35, 0, 11, 20));
    put(0, 14, enc_i(35, 0, 12, 8));
    put(0, 15, enc_i(35, 0, 13, 16));
    put(0, 16, enc_i(4, 1, 2, 5));
    put(0, 17, enc_i(4, 11, 1, 2));
    put(0, 18, enc_r(1, 1, 20, 32));
    put(0, 19, enc_r(1, 1, 20, 32));
    put(0, 20, enc_j(23));
    put(0, 21, enc_r(1, 1, 21, 32));
    put(0, 22, enc_r(1, 1, 21, 32));
    put(0, 23, enc_r(12, 12, 14, 32));
    put(0, 96, enc_r(1, 1, 15, 32));
    put(0, 97, 32'hFC00_0000);
    check_reset();
    run(30);

    // Phase B: negative branch offset, subtract overflow
    enter_reset();
    put(0, 0, enc_i(35, 0, 1, 8));
    put(0, 1, enc_i(35, 0, 2, 12));
    put(0, 2, enc_i(4, 0, 0, 2));
    put(0, 3, enc_r(1, 2, 4, 34));
    put(0, 4, enc_r(1, 0, 16, 32));
    put(0, 5, enc_i(4, 0, 0, -3));
    check_reset();
    run(12);

    // Phase C: loads offered while running are dropped; illegal function code
    enter_reset();
    put(0, 0, enc_i(35, 0, 7, 0));
    put(0, 1, enc_r(2, 1, 8, 42));
    put(0, 2, enc_r(1, 2, 9, 63));
    check_reset();
    ld_valid = 1'b1; ld_sel = 1'b1; ld_addr = 7'd0; ld_data = 32'hDEAD_BEEF;
    run(3);
    ld_valid = 1'b0;
    run(5);

    // Phase D: nonzero shift field in an R-type word; drop-check read-back
    enter_reset();
    put(0, 0, enc_i(35, 0, 17, 0));
    put(0, 1, enc_r(1, 1, 18, 32, 1));
    check_reset();
    run(6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule